// File: doc/BRIEF.md
# Branch Resolution and Static Prediction Unit

This unit sits beside an instruction fetch stage. It takes at most one decoded branch per cycle and answers, in the same cycle, the address fetch should use next. Targets come from three sources: the branch address plus a displacement, a private link register, or a private count register. Every target is forced to word alignment. The unit also owns a condition register with a pending-write mask. It therefore needs no access to the general register files.

When the condition bit a branch tests is already settled, the branch is resolved on the spot and costs no extra cycle. When an older instruction still owes that bit, the unit follows the static hint bit carried in the branch, parks the branch and raises `hold`. When the bit arrives, the unit checks the outcome against the hint and pulses a redirect with the correct address if the guess was wrong. Link writes and count decrements wait for resolution. A general register port can load and read the link and count registers.

Top module: `branch_steer`

## Requirements
- R1: After reset, the link and count registers read zero, every condition bit is zero and no bit is pending, and `hold` and `redirect` are low.
- R2: `br_tsel` selects the target: 0 and 3 give `br_pc + br_disp`, 1 gives the link register, 2 gives the count register. Bits [1:0] of every target are forced to zero.
- R3: An accepted branch that is unconditional, or whose tested bit is not pending, is resolved in the same cycle. `next_pc` is the target if the branch is taken, otherwise `br_pc + 4`. The hint has no effect and no redirect follows. A conditional branch is taken only if condition bit `br_crbit` equals `br_sense`.
- R4: An accepted conditional branch whose tested bit is pending is deferred. `next_pc` is the target when `br_hint` is 1, otherwise `br_pc + 4`. `hold` is high from the next cycle until the branch resolves.
- R5: A deferred branch resolves in the first cycle in which `hold` is high and its bit is no longer pending. A write on the `cr_wr` port clears the pending mark at the clock edge. In the resolving cycle, `redirect` is high for that one cycle exactly when the outcome differs from the hint, and `redirect_pc` gives the correct next address. `hold` is low in the following cycle.
- R6: When `br_usectr` is set, the taken condition also requires `(count - 1 == 0) == br_ctrzero`, and the count register is decremented at the clock edge that ends the resolving cycle. A deferred branch does not change the count register before it resolves.
- R7: When `br_link` is set, the link register receives `br_pc + 4` at resolution. A branch that both links and targets the link register uses the old link value as its target.
- R8: `reg_wr` writes `reg_wr_data` to the link register (`reg_wr_sel` = 0) or the count register (`reg_wr_sel` = 1). `reg_rd_data` shows the register chosen by `reg_rd_sel` in the same cycle. If a branch commit writes the same register in the same cycle, the commit wins.
- R9: While `hold` is high, a presented branch is ignored: `next_pc` is `br_pc + 4` and no register changes because of it. The same `next_pc` applies when `br_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch is presented |
| br_pc | input | AW | Address of the branch |
| br_disp | input | AW | Sign-extended displacement |
| br_tsel | input | 2 | Target source select |
| br_cond | input | 1 | Branch tests a condition bit |
| br_crbit | input | CIW | Index of the tested condition bit |
| br_sense | input | 1 | Bit value that makes the branch taken |
| br_usectr | input | 1 | Decrement count and test it |
| br_ctrzero | input | 1 | Count test requires zero (1) or nonzero (0) |
| br_link | input | 1 | Write return address to link register |
| br_hint | input | 1 | Static prediction: 1 means taken |
| cr_mark | input | 1 | Mark a condition bit as pending |
| cr_mark_idx | input | CIW | Bit to mark |
| cr_wr | input | 1 | Write a condition bit and clear its pending mark |
| cr_wr_idx | input | CIW | Bit to write |
| cr_wr_val | input | 1 | Value written |
| reg_wr | input | 1 | General register port write |
| reg_wr_sel | input | 1 | 0 link, 1 count |
| reg_wr_data | input | AW | Write data |
| reg_rd_sel | input | 1 | 0 link, 1 count |
| reg_rd_data | output | AW | Read data |
| next_pc | output | AW | Next fetch address for the presented branch |
| hold | output | 1 | A deferred branch is outstanding |
| redirect | output | 1 | Misprediction pulse |
| redirect_pc | output | AW | Correct address during a redirect |

## Verification
The bench first drives directed cases: targets built from relative, link and count sources with unaligned raw values; a count loop that runs down to zero; and a deferred branch that is mispredicted. During that branch it also presents an ignored branch and a port write. These separate errors in target selection, alignment masking, count-test polarity and commit timing. Random traffic then concentrates branches on four condition bits, with frequent marks and writes to those bits. This mix produces deferred branches that resolve correctly and ones that resolve wrongly. It also covers bypass-free resolution and branches arriving while `hold` is high. A reference model built from the requirements tells a hint-driven guess apart from a true resolution.

// File: rtl/branch_steer.sv
module branch_steer #(
  parameter int AW  = 32,
  parameter int CRN = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   br_valid,
  input  logic [AW-1:0]          br_pc,
  input  logic [AW-1:0]          br_disp,
  input  logic [1:0]             br_tsel,
  input  logic                   br_cond,
  input  logic [$clog2(CRN)-1:0] br_crbit,
  input  logic                   br_sense,
  input  logic                   br_usectr,
  input  logic                   br_ctrzero,
  input  logic                   br_link,
  input  logic                   br_hint,
  input  logic                   cr_mark,
  input  logic [$clog2(CRN)-1:0] cr_mark_idx,
  input  logic                   cr_wr,
  input  logic [$clog2(CRN)-1:0] cr_wr_idx,
  input  logic                   cr_wr_val,
  input  logic                   reg_wr,
  input  logic                   reg_wr_sel,
  input  logic [AW-1:0]          reg_wr_data,
  input  logic                   reg_rd_sel,
  output logic [AW-1:0]          reg_rd_data,
  output logic [AW-1:0]          next_pc,
  output logic                   hold,
  output logic                   redirect,
  output logic [AW-1:0]          redirect_pc
);
  localparam int CIW = $clog2(CRN);

  logic [AW-1:0]  lr_q, ctr_q;
  logic [CRN-1:0] cr_q, crp_q;
  logic           pend_q, p_hint, p_sense, p_usectr, p_ctrzero, p_link;
  logic [AW-1:0]  p_tgt, p_fall;
  logic [CIW-1:0] p_idx;

  logic [AW-1:0]  ctr_dec, tgt_raw, tgt, fall;
  logic           accept, defer, now_taken, resolve_now, resolving, p_taken;
  logic           c_en, c_dec, c_link;
  logic [AW-1:0]  c_fall;
  logic [CRN-1:0] wr_mask, mark_mask;

  assign ctr_dec = ctr_q - AW'(1);
  assign accept  = br_valid && !pend_q;
  assign fall    = br_pc + AW'(4);

  always_comb begin
    case (br_tsel)
      2'd1:    tgt_raw = lr_q;
      2'd2:    tgt_raw = ctr_q;
      default: tgt_raw = br_pc + br_disp;
    endcase
  end
  assign tgt = {tgt_raw[AW-1:2], 2'b00};

  assign defer       = accept && br_cond && crp_q[br_crbit];
  assign resolve_now = accept && !defer;
  assign now_taken   = (!br_cond || (cr_q[br_crbit] == br_sense)) &&
                       (!br_usectr || ((ctr_dec == '0) == br_ctrzero));

  always_comb begin
    if (!accept)    next_pc = fall;
    else if (defer) next_pc = br_hint ? tgt : fall;
    else            next_pc = now_taken ? tgt : fall;
  end

  assign resolving   = pend_q && !crp_q[p_idx];
  assign p_taken     = (cr_q[p_idx] == p_sense) &&
                       (!p_usectr || ((ctr_dec == '0) == p_ctrzero));
  assign redirect    = resolving && (p_taken != p_hint);
  assign redirect_pc = p_taken ? p_tgt : p_fall;
  assign hold        = pend_q;
  assign reg_rd_data = reg_rd_sel ? ctr_q : lr_q;

  assign c_en   = resolve_now || resolving;
  assign c_dec  = c_en && (resolve_now ? br_usectr : p_usectr);
  assign c_link = c_en && (resolve_now ? br_link : p_link);
  assign c_fall = resolve_now ? fall : p_fall;

  assign wr_mask   = cr_wr   ? ({{(CRN-1){1'b0}}, 1'b1} << cr_wr_idx)   : '0;
  assign mark_mask = cr_mark ? ({{(CRN-1){1'b0}}, 1'b1} << cr_mark_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lr_q  <= '0;
      ctr_q <= '0;
      cr_q  <= '0;
      crp_q <= '0;
    end else begin
      if (c_link)                   lr_q <= c_fall;
      else if (reg_wr && !reg_wr_sel) lr_q <= reg_wr_data;
      if (c_dec)                    ctr_q <= ctr_dec;
      else if (reg_wr && reg_wr_sel)  ctr_q <= reg_wr_data;
      if (cr_wr) cr_q[cr_wr_idx] <= cr_wr_val;
      crp_q <= (crp_q & ~wr_mask) | mark_mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q    <= 1'b0;
      p_tgt     <= '0;
      p_fall    <= '0;
      p_idx     <= '0;
      p_hint    <= 1'b0;
      p_sense   <= 1'b0;
      p_usectr  <= 1'b0;
      p_ctrzero <= 1'b0;
      p_link    <= 1'b0;
    end else if (resolving) begin
      pend_q <= 1'b0;
    end else if (defer) begin
      pend_q    <= 1'b1;
      p_tgt     <= tgt;
      p_fall    <= fall;
      p_idx     <= br_crbit;
      p_hint    <= br_hint;
      p_sense   <= br_sense;
      p_usectr  <= br_usectr;
      p_ctrzero <= br_ctrzero;
      p_link    <= br_link;
    end
  end
endmodule

module branch_steer_chk #(parameter int AW = 32) (
  input logic          clk,
  input logic          rst_n,
  input logic          redirect,
  input logic          hold,
  input logic          resolving,
  input logic          resolve_now,
  input logic          br_link,
  input logic [AW-1:0] br_pc,
  input logic          reg_wr,
  input logic          reg_wr_sel,
  input logic [AW-1:0] lr_q,
  input logic [AW-1:0] ctr_q
);
  a_r5_redirect_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> !redirect);
  a_r5_redirect_needs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> hold);
  a_r5_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    resolving |=> !hold);
  a_r7_link_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (resolve_now && br_link) |=> (lr_q == $past(br_pc) + AW'(4)));
  a_r6_ctr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !resolving && !(reg_wr && reg_wr_sel)) |=> (ctr_q == $past(ctr_q)));
endmodule

bind branch_steer branch_steer_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .redirect(redirect), .hold(hold),
  .resolving(resolving), .resolve_now(resolve_now), .br_link(br_link),
  .br_pc(br_pc), .reg_wr(reg_wr), .reg_wr_sel(reg_wr_sel),
  .lr_q(lr_q), .ctr_q(ctr_q)
);

// File: tb/tb_branch_steer.sv
module tb_branch_steer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        br_valid = 0, br_cond = 0, br_sense = 0, br_usectr = 0;
  logic        br_ctrzero = 0, br_link = 0, br_hint = 0;
  logic [31:0] br_pc = 0, br_disp = 0;
  logic [1:0]  br_tsel = 0;
  logic [4:0]  br_crbit = 0, cr_mark_idx = 0, cr_wr_idx = 0;
  logic        cr_mark = 0, cr_wr = 0, cr_wr_val = 0;
  logic        reg_wr = 0, reg_wr_sel = 0, reg_rd_sel = 0;
  logic [31:0] reg_wr_data = 0;
  logic [31:0] reg_rd_data, next_pc, redirect_pc;
  logic        hold, redirect;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  branch_steer dut (.*);

  logic [31:0] m_lr, m_ctr, m_cr, m_crp, mp_tgt, mp_fall;
  logic        m_pend, mp_hint, mp_sense, mp_use, mp_zero, mp_link;
  logic [4:0]  mp_idx;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] f_tgt(input logic [1:0] sel, input logic [31:0] pc,
                                        input logic [31:0] d, input logic [31:0] lr,
                                        input logic [31:0] ctr);
    logic [31:0] t;
    t = (sel == 2'd1) ? lr : (sel == 2'd2) ? ctr : pc + d;
    return t & 32'hFFFF_FFFC;
  endfunction

  function automatic logic f_cok(input logic [31:0] ctr, input logic use_c, input logic z);
    return !use_c || (((ctr - 1) == 0) == z);
  endfunction

  task automatic step();
    logic acc, dfr, tk, res, ptk, e_red;
    logic [31:0] tgt, fall, e_next;
    #2;
    acc  = br_valid && !m_pend;
    fall = br_pc + 4;
    tgt  = f_tgt(br_tsel, br_pc, br_disp, m_lr, m_ctr);
    dfr  = acc && br_cond && m_crp[br_crbit];
    tk   = (!br_cond || m_cr[br_crbit] == br_sense) && f_cok(m_ctr, br_usectr, br_ctrzero);
    e_next = !acc ? fall : dfr ? (br_hint ? tgt : fall) : (tk ? tgt : fall);
    res  = m_pend && !m_crp[mp_idx];
    ptk  = (m_cr[mp_idx] == mp_sense) && f_cok(m_ctr, mp_use, mp_zero);
    e_red = res && (ptk != mp_hint);
    chk(!acc ? "R9 next_pc ignored" : dfr ? "R4 next_pc hint" : "R3 next_pc resolved",
        next_pc, e_next);
    chk("R4 hold", {31'b0, hold}, {31'b0, m_pend});
    chk("R5 redirect", {31'b0, redirect}, {31'b0, e_red});
    if (e_red) chk("R5 redirect_pc", redirect_pc, ptk ? mp_tgt : mp_fall);
    chk("R8 reg_rd_data", reg_rd_data, reg_rd_sel ? m_ctr : m_lr);
    @(posedge clk);
    if (acc && !dfr && br_link) m_lr = fall;
    else if (res && mp_link)    m_lr = mp_fall;
    else if (reg_wr && !reg_wr_sel) m_lr = reg_wr_data;
    if ((acc && !dfr && br_usectr) || (res && mp_use)) m_ctr = m_ctr - 1;
    else if (reg_wr && reg_wr_sel) m_ctr = reg_wr_data;
    if (cr_wr) begin m_cr[cr_wr_idx] = cr_wr_val; m_crp[cr_wr_idx] = 1'b0; end
    if (cr_mark) m_crp[cr_mark_idx] = 1'b1;
    if (res) m_pend = 1'b0;
    else if (dfr) begin
      m_pend = 1'b1; mp_tgt = tgt; mp_fall = fall; mp_idx = br_crbit; mp_hint = br_hint;
      mp_sense = br_sense; mp_use = br_usectr; mp_zero = br_ctrzero; mp_link = br_link;
    end
    #1;
  endtask

  task automatic idle();
    br_valid = 0; cr_mark = 0; cr_wr = 0; reg_wr = 0;
  endtask

  task automatic branch(input logic [31:0] pc, input logic [31:0] d, input logic [1:0] sel,
                        input logic cnd, input logic [4:0] bit_i, input logic sns,
                        input logic uc, input logic z, input logic lk, input logic h);
    br_valid = 1; br_pc = pc; br_disp = d; br_tsel = sel; br_cond = cnd; br_crbit = bit_i;
    br_sense = sns; br_usectr = uc; br_ctrzero = z; br_link = lk; br_hint = h;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    m_lr = 0; m_ctr = 0; m_cr = 0; m_crp = 0; m_pend = 0; mp_tgt = 0; mp_fall = 0;
    mp_idx = 0; mp_hint = 0; mp_sense = 0; mp_use = 0; mp_zero = 0; mp_link = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    idle(); reg_rd_sel = 0; #1;
    chk("R1 lr after reset", reg_rd_data, 32'h0);
    chk("R1 hold after reset", {31'b0, hold}, 32'h0);
    reg_rd_sel = 1; #1;
    chk("R1 ctr after reset", reg_rd_data, 32'h0);
    branch(32'h100, 32'h10, 2'd0, 1, 5'd7, 0, 0, 0, 0, 0); #1;
    chk("R1 cr bit zero taken", next_pc, 32'h110);
    step();

    // R2 relative with unaligned sum, select 3
    branch(32'h1000, 32'h23, 2'd3, 0, 0, 0, 0, 0, 0, 0); #1;
    chk("R2 relative masked", next_pc, 32'h1020);
    step();

    // R8 port write, R7 link-target uses old link
    idle(); reg_wr = 1; reg_wr_sel = 0; reg_wr_data = 32'h2222_0003; step();
    reg_wr = 0; reg_rd_sel = 0; #1;
    chk("R8 lr port read", reg_rd_data, 32'h2222_0003);
    branch(32'h40, 0, 2'd1, 0, 0, 0, 0, 0, 1, 0); #1;
    chk("R7 old link target", next_pc, 32'h2222_0000);
    step(); idle(); #1;
    chk("R7 link written", reg_rd_data, 32'h44);

    // R6 count loop: taken while count-1 nonzero
    reg_wr = 1; reg_wr_sel = 1; reg_wr_data = 32'h2; step(); reg_wr = 0;
    branch(32'h200, 32'hFFFF_FFF0, 2'd0, 0, 0, 0, 1, 0, 0, 0); #1;
    chk("R6 count taken", next_pc, 32'h1F0);
    step();
    branch(32'h200, 32'hFFFF_FFF0, 2'd0, 0, 0, 0, 1, 0, 0, 0); #1;
    chk("R6 count exit", next_pc, 32'h204);
    step(); idle(); reg_rd_sel = 1; #1;
    chk("R6 count at zero", reg_rd_data, 32'h0);

    // R2 count-register target
    reg_wr = 1; reg_wr_sel = 1; reg_wr_data = 32'h0000_8007; step(); reg_wr = 0;
    branch(32'h300, 0, 2'd2, 0, 0, 0, 0, 0, 0, 0); #1;
    chk("R2 count target masked", next_pc, 32'h8004);
    step();

    // R4/R5/R9 deferred mispredict
    idle(); cr_mark = 1; cr_mark_idx = 3; step(); cr_mark = 0;
    branch(32'h500, 32'h80, 2'd0, 1, 5'd3, 1, 0, 0, 1, 0); #1;
    chk("R4 follow hint", next_pc, 32'h504);
    step();
    branch(32'h900, 32'h8, 2'd0, 0, 0, 0, 1, 0, 1, 1);
    reg_wr = 1; reg_wr_sel = 1; reg_wr_data = 32'h5; #1;
    chk("R4 hold high", {31'b0, hold}, 32'h1);
    chk("R9 ignored next_pc", next_pc, 32'h904);
    step(); idle(); reg_rd_sel = 0; #1;
    chk("R9 lr untouched", reg_rd_data, 32'h44);
    cr_wr = 1; cr_wr_idx = 3; cr_wr_val = 1; step(); cr_wr = 0; #1;
    chk("R5 redirect raised", {31'b0, redirect}, 32'h1);
    chk("R5 redirect target", redirect_pc, 32'h580);
    step(); #1;
    chk("R5 redirect one cycle", {31'b0, redirect}, 32'h0);
    chk("R5 hold released", {31'b0, hold}, 32'h0);
    chk("R7 deferred link", reg_rd_data, 32'h504);
    step();

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      br_valid = r[0] | r[1];
      br_pc = $urandom & 32'h000F_FFFC;
      br_disp = $urandom & 32'h0000_0FFF;
      br_tsel = r[3:2]; br_cond = r[4] | r[5]; br_crbit = {3'b0, r[7:6]};
      br_sense = r[8]; br_usectr = r[9] & r[10]; br_ctrzero = r[11];
      br_link = r[12]; br_hint = r[13];
      cr_mark = (r[17:14] == 0) | (r[17:14] == 1); cr_mark_idx = {3'b0, r[19:18]};
      cr_wr = r[22:20] < 2; cr_wr_idx = {3'b0, r[24:23]}; cr_wr_val = r[25];
      if (cr_wr && cr_mark && cr_wr_idx == cr_mark_idx) cr_mark = 0;
      reg_wr = r[28:26] == 0; reg_wr_sel = r[29]; reg_rd_sel = r[30];
      reg_wr_data = (r[31] ? 32'h3 : $urandom) ;
      step();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end
endmodule